// File: doc/BRIEF.md
# Dual-I/O Read Serializer

This block is the datapath behind the two-bit-per-clock fast-read commands of a serial flash slave. An upstream decoder recognises the opcode and pulses `cmd_go` with `cmd_dual_io` choosing the variant. The block then collects a 24-bit start address from the serial pins. In dual-output mode the address comes one bit per SCK on `dio_i`. In dual-I/O mode it comes two bits per SCK on `do_i`/`dio_i`. After a dummy phase it streams data bytes back two bits per SCK until chip select rises.

Bytes come from a synchronous byte-wide read port. The block presents `rd_addr` together with a one-cycle `rd_req` and captures `rd_data` `RD_LAT` cycles later. The next byte is prefetched while the current one is being shifted out. `sck`, `cs_n` and the data inputs are taken as already synchronous to `clk`, and SCK edges are detected in the `clk` domain. Inputs are acted on at rising SCK edges and outputs change after falling SCK edges. The two output enables stay low until the data phase begins.

Top module: `dio_rd_serializer`

## Requirements
- R1: After synchronous reset, `dio_oe`, `do_oe`, `dio_o`, `do_o` and `rd_req` are 0 and `rd_addr` is 0.
- R2: With `cmd_dual_io`=0, the address is 24 bits taken from `dio_i` at 24 rising SCK edges, most significant bit first. `do_i` is ignored. The first `rd_req` after the last address edge carries that address on `rd_addr`.
- R3: With `cmd_dual_io`=1, the address is taken at 12 rising SCK edges, most significant pair first. `do_i` carries the odd bit (A23, A21 … A1) and `dio_i` the even bit (A22 … A0).
- R4: The dummy phase lasts 8 rising SCK edges in dual-output mode and 4 in dual-I/O mode, and the values sampled in it have no effect. Both output enables stay 0 through the address and dummy phases.
- R5: Both output enables rise right after the first falling SCK edge that follows the last dummy edge. Each byte then leaves over four falling edges, most significant pair first, with D7/D5/D3/D1 on `do_o` and D6/D4/D2/D0 on `dio_o`. The outputs hold between falling edges.
- R6: Bytes stream without limit. The address advances by one per byte and wraps from FFFFFFh to 000000h.
- R7: `cs_n` high in any phase returns the block to idle. The output enables are 0 from the next cycle, and no further `rd_req` is issued.
- R8: `cmd_go` is ignored while a read is in progress and while `cs_n` is high.
- R9: `rd_req` is a single-cycle pulse. One is issued at the end of the address phase, and one more each time a byte starts to shift out. `rd_data` is taken `RD_LAT` cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, sampled in the `clk` domain |
| cmd_go | input | 1 | Start pulse from the opcode decoder |
| cmd_dual_io | input | 1 | 0: address on one pin; 1: address on two pins |
| dio_i | input | 1 | Input value of the DIO pin |
| do_i | input | 1 | Input value of the DO pin |
| dio_o | output | 1 | Output value for the DIO pin (even data bits) |
| dio_oe | output | 1 | Output enable of the DIO pin |
| do_o | output | 1 | Output value for the DO pin (odd data bits) |
| do_oe | output | 1 | Output enable of the DO pin |
| rd_req | output | 1 | Read strobe to the byte port |
| rd_addr | output | 24 | Byte address for the read port |
| rd_data | input | 8 | Byte returned by the read port |

## Verification
The assertions cover the behaviour that can be stated at any edge. These are the release of both enables and the stop of read strobes after chip select rises, the single-cycle strobe, the enables rising only just after a falling SCK edge, and the output pair holding still between falling edges. The bench scenarios cover what needs a whole transfer to show: address assembly in both pin layouts, the two dummy lengths, the bit order of each byte, address increment across the 24-bit wrap, an abort in the middle of a byte, and start pulses that arrive while busy or deselected.

// File: rtl/dio_rd_pkg.sv
package dio_rd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ADDR  = 2'd1,
    PH_DUMMY = 2'd2,
    PH_DATA  = 2'd3
  } phase_t;
endpackage

// File: rtl/dio_rd_edge.sv
// Detects SCK transitions in the system clock domain.
module dio_rd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  output logic rise,
  output logic fall
);
  logic sck_q;

  always_ff @(posedge clk) begin
    if (rst) sck_q <= 1'b0;
    else     sck_q <= sck;
  end

  assign rise = sck & ~sck_q;
  assign fall = ~sck & sck_q;
endmodule

// File: rtl/dio_rd_fetch.sv
// Address counter, read strobe and one-byte prefetch register.
module dio_rd_fetch #(
  parameter int AW     = 24,
  parameter int DW     = 8,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          adv,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] nxt_byte
);
  logic [RD_LAT-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_addr <= '0;
    end else begin
      rd_req <= load | adv;
      if (load)     rd_addr <= load_addr;
      else if (adv) rd_addr <= rd_addr + AW'(1);
    end
  end

  generate
    if (RD_LAT == 1) begin : g_lat1
      always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= rd_req;
      end
    end else begin : g_latn
      always_ff @(posedge clk) begin
        if (rst) vld <= '0;
        else     vld <= {vld[RD_LAT-2:0], rd_req};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                  nxt_byte <= '0;
    else if (vld[RD_LAT-1])   nxt_byte <= rd_data;
  end
endmodule

// File: rtl/dio_rd_shift.sv
// Splits each byte by bit parity onto two pins, one pair per step.
module dio_rd_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          step,
  input  logic [DW-1:0] nxt_byte,
  output logic          pin_odd,
  output logic          pin_even,
  output logic          oe,
  output logic          take
);
  localparam int PAIRS = DW / 2;
  localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic [PW-1:0] pair;
  logic [DW-1:0] sh;

  assign take = step & (pair == '0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pair     <= '0;
      sh       <= '0;
      oe       <= 1'b0;
      pin_odd  <= 1'b0;
      pin_even <= 1'b0;
    end else if (step) begin
      oe <= 1'b1;
      if (take) begin
        pin_odd  <= nxt_byte[DW-1];
        pin_even <= nxt_byte[DW-2];
        sh       <= {nxt_byte[DW-3:0], 2'b00};
      end else begin
        pin_odd  <= sh[DW-1];
        pin_even <= sh[DW-2];
        sh       <= {sh[DW-3:0], 2'b00};
      end
      pair <= (pair == PW'(PAIRS - 1)) ? '0 : pair + PW'(1);
    end
  end
endmodule

// File: rtl/dio_rd_serializer.sv
module dio_rd_serializer
  import dio_rd_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 8,
  parameter int RD_LAT     = 1,
  parameter int DUMMY_SGL  = 8,
  parameter int DUMMY_DUAL = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          sck,
  input  logic          cmd_go,
  input  logic          cmd_dual_io,
  input  logic          dio_i,
  input  logic          do_i,
  output logic          dio_o,
  output logic          dio_oe,
  output logic          do_o,
  output logic          do_oe,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data
);
  localparam int ADDR_SGL  = AW;
  localparam int ADDR_DUAL = AW / 2;
  localparam int MAXC      = (AW > DUMMY_SGL) ? AW : DUMMY_SGL;
  localparam int CW        = $clog2(MAXC);

  phase_t        ph;
  logic          dual;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ash;
  logic          rise, fall;
  logic [AW-1:0] addr_next;
  logic          addr_last, dummy_last;
  logic          load, step, take, oe;
  logic [DW-1:0] nxt_byte;

  dio_rd_edge u_edge (
    .clk  (clk),
    .rst  (rst),
    .sck  (sck),
    .rise (rise),
    .fall (fall)
  );

  assign addr_next  = dual ? {ash[AW-3:0], do_i, dio_i} : {ash[AW-2:0], dio_i};
  assign addr_last  = (cnt == (dual ? CW'(ADDR_DUAL - 1) : CW'(ADDR_SGL - 1)));
  assign dummy_last = (cnt == (dual ? CW'(DUMMY_DUAL - 1) : CW'(DUMMY_SGL - 1)));
  assign load       = (ph == PH_ADDR) & rise & addr_last & ~cs_n;
  assign step       = (ph == PH_DATA) & fall & ~cs_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= PH_IDLE;
      dual <= 1'b0;
      cnt  <= '0;
      ash  <= '0;
    end else if (cs_n) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (cmd_go) begin
            ph   <= PH_ADDR;
            dual <= cmd_dual_io;
            cnt  <= '0;
          end
        end
        PH_ADDR: begin
          if (rise) begin
            ash <= addr_next;
            if (addr_last) begin
              ph  <= PH_DUMMY;
              cnt <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        PH_DUMMY: begin
          if (rise) begin
            if (dummy_last) begin
              ph  <= PH_DATA;
              cnt <= '0;
            end else begin
              cnt <= cnt + CW'(1);
            end
          end
        end
        PH_DATA: ;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  dio_rd_fetch #(
    .AW     (AW),
    .DW     (DW),
    .RD_LAT (RD_LAT)
  ) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_addr (addr_next),
    .adv       (take),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .nxt_byte  (nxt_byte)
  );

  dio_rd_shift #(
    .DW (DW)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .clear    (cs_n | (ph != PH_DATA)),
    .step     (step),
    .nxt_byte (nxt_byte),
    .pin_odd  (do_o),
    .pin_even (dio_o),
    .oe       (oe),
    .take     (take)
  );

  assign dio_oe = oe;
  assign do_oe  = oe;
endmodule

// File: rtl/dio_rd_checker.sv
module dio_rd_checker (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic sck,
  input logic rd_req,
  input logic dio_oe,
  input logic do_oe,
  input logic dio_o,
  input logic do_o
);
  AST_CS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!dio_oe && !do_oe)); // R7
  AST_CS_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !rd_req); // R7
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req); // R9
  AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(do_oe) |-> ($past(sck, 2) && !$past(sck))); // R5
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (do_oe && $past(do_oe) && !($past(sck, 2) && !$past(sck)))
      |-> ($stable(do_o) && $stable(dio_o))); // R5
endmodule

bind dio_rd_serializer dio_rd_checker u_chk (.*);

// File: tb/dio_rd_serializer_test.sv
module dio_rd_serializer_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic        cmd_go = 1'b0;
  logic        cmd_dual_io = 1'b0;
  logic        dio_i = 1'b0;
  logic        do_i = 1'b0;
  logic        dio_o, dio_oe, do_o, do_oe, rd_req;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data;

  int n_chk = 0;
  int n_fail = 0;
  int req_total = 0;
  logic [23:0] last_req_addr = '0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dio_rd_serializer uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .cmd_go(cmd_go),
    .cmd_dual_io(cmd_dual_io), .dio_i(dio_i), .do_i(do_i),
    .dio_o(dio_o), .dio_oe(dio_oe), .do_o(do_o), .do_oe(do_oe),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic logic [7:0] mem_fn(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ (a[23:16] + 8'h5A);
  endfunction

  // read port model, latency of one cycle
  always @(posedge clk) rd_data <= mem_fn(rd_addr);

  always @(posedge clk) begin
    if (!rst && rd_req) begin
      req_total     <= req_total + 1;
      last_req_addr <= rd_addr;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sclk_in(bit hi, bit lo);
    sck = 1'b0; tick(2);
    do_i = hi; dio_i = lo; tick(2);
    sck = 1'b1; tick(4);
    chk(!dio_oe && !do_oe, "R4 enables low before data", {dio_oe, do_oe}, 0);
  endtask

  task automatic sclk_out(output bit hi, output bit lo);
    sck = 1'b0; tick(3);
    hi = do_o; lo = dio_o;
    chk(dio_oe && do_oe, "R5 enables high in data", {dio_oe, do_oe}, 3);
    tick(1);
    sck = 1'b1; tick(4);
  endtask

  task automatic do_read(bit dual, logic [23:0] a, int nbytes, int abort_pairs, bit go_mid);
    int base, pairs_done, falls0;
    bit h, l, stop;
    logic [7:0] got, expb;
    base = req_total;
    cs_n = 1'b0; tick(2);
    cmd_go = 1'b1; cmd_dual_io = dual; tick(1);
    cmd_go = 1'b0; tick(1);
    if (dual) begin
      for (int i = 11; i >= 0; i--) sclk_in(a[2*i+1], a[2*i]);
    end else begin
      for (int i = 23; i >= 0; i--) sclk_in(1'($urandom % 2), a[i]);
    end
    tick(2);
    chk(req_total == base + 1, "R9 one fetch after address", req_total - base, 1);
    chk(last_req_addr == a, dual ? "R3 dual address" : "R2 single address", last_req_addr, a);
    for (int i = 0; i < (dual ? 4 : 8); i++) sclk_in(1'($urandom % 2), 1'($urandom % 2));
    pairs_done = 0;
    stop = 0;
    for (int b = 0; b < nbytes && !stop; b++) begin
      expb = mem_fn(a + 24'(b));
      got = '0;
      for (int p = 0; p < 4; p++) begin
        if (abort_pairs >= 0 && pairs_done == abort_pairs) begin
          stop = 1;
          break;
        end
        sclk_out(h, l);
        got = {got[5:0], h, l};
        pairs_done++;
        if (go_mid && b == 0 && p == 1) begin
          cmd_go = 1'b1; cmd_dual_io = ~dual; tick(1);
          cmd_go = 1'b0; tick(1);
        end
      end
      if (!stop)
        chk(got == expb, b == 0 ? "R4 R5 first byte" : (go_mid ? "R8 byte after busy go" : "R6 next byte"), got, expb);
    end
    cs_n = 1'b1; tick(3);
    chk(!dio_oe && !do_oe, "R7 enables off after deselect", {dio_oe, do_oe}, 0);
    sck = 1'b0; tick(20);
    falls0 = (pairs_done + 3) / 4;
    chk(req_total == base + 1 + falls0, abort_pairs >= 0 ? "R7 no fetch after deselect" : "R9 fetch count",
        req_total - base, 1 + falls0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd4711));
    tick(5);
    rst = 1'b0;
    tick(1);
    chk(!dio_oe && !do_oe && !dio_o && !do_o, "R1 reset pins", {dio_oe, do_oe, dio_o, do_o}, 0);
    chk(!rd_req && rd_addr == 0, "R1 reset fetch", rd_addr, 0);

    do_read(1'b0, 24'h123456, 3, -1, 1'b0);
    do_read(1'b1, 24'hA5C3F0, 2, -1, 1'b0);
    do_read(1'b1, 24'hFFFFFE, 4, -1, 1'b0);   // R6 wrap
    do_read(1'b0, 24'hFFFFFF, 2, -1, 1'b0);   // R6 wrap
    do_read(1'b1, 24'h00F00D, 3, 5, 1'b0);    // R7 abort mid byte
    do_read(1'b0, 24'h3C3C3C, 2, -1, 1'b1);   // R8 go while busy

    // R8: start pulse while deselected is ignored
    base = req_total;
    cs_n = 1'b1; tick(2);
    cmd_go = 1'b1; cmd_dual_io = 1'b0; tick(1);
    cmd_go = 1'b0; tick(1);
    cs_n = 1'b0; tick(2);
    for (int i = 0; i < 40; i++) sclk_in(1'($urandom % 2), 1'($urandom % 2));
    sck = 1'b0; tick(4);
    chk(req_total == base, "R8 no start while deselected", req_total - base, 0);
    chk(!dio_oe && !do_oe, "R8 pins stay input", {dio_oe, do_oe}, 0);
    cs_n = 1'b1; tick(4);

    for (int t = 0; t < 8; t++)
      do_read(1'($urandom % 2), 24'($urandom), 1 + int'($urandom % 3), -1, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule